// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Summary Word

This block gathers up to 72 level-sensitive interrupt lines into three banks and drives one interrupt request to a processor. Bank 0 holds 8 local lines. Banks 1 and 2 each hold 32 peripheral lines. Each bank has a mask of enable bits. Software sets these bits through a write-one-to-set word and clears them through a separate write-one-to-clear word. A line counts as pending only while its input is high and its enable bit is set. The block keeps no latched state for a line: a pending line clears as soon as its input drops.

To find the cause of an interrupt, software reads one summary word first. That word gives the masked local lines directly. It has one "any pending" flag for each peripheral bank. It also has eleven shortcut bits that mirror chosen peripheral lines, so a handler for a common source can skip reading the bank. Software reads a per-bank pending word only when the summary does not identify the source.

The register port is a simple valid/write/word-address/data bus. Read data is registered and appears the cycle after the request.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Synchronous reset clears every enable bit. After reset, `irq_o` is 0 and every pending word and the summary word read 0, whatever the inputs are.
- R2: A write to word address 4+b (b = 0, 1 or 2) sets the enable bits of bank b wherever the write data has a 1. Zero bits leave the enables unchanged. For bank 0, data bits 31:8 are ignored.
- R3: A write to word address 8+b clears the enable bits of bank b wherever the write data has a 1. Zero bits leave the enables unchanged.
- R4: A read of word 4+b or word 8+b returns the current enable mask of bank b. For bank 0, bits 31:8 read 0.
- R5: A read of word 1+b returns the input levels of bank b ANDed with its enables.
- R6: Bits 7:0 of the summary word (address 0) are the masked pending bits of bank 0.
- R7: Summary bit 8 is 1 when any enabled line of bank 1 is pending. Summary bit 9 is the same flag for bank 2.
- R8: Summary bits 10 to 14 mirror the masked pending state of bank-1 lines 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 mirror bank-2 lines 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read 0.
- R9: `irq_o` is a register that holds the OR of all masked pending lines. It follows an input change one clock later.
- R10: Interrupts are level-sensitive. When an input drops, its pending bit, its summary bits and `irq_o` clear without any acknowledge.
- R11: Read data is registered and is valid the cycle after a read request. It holds until the next read. Addresses 7 and 11 to 15 read 0.
- R12: Writes to the summary word, the pending words or an unmapped address have no effect on any enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_local_i | input | 8 | Bank-0 level inputs |
| src_per1_i | input | 32 | Bank-1 level inputs |
| src_per2_i | input | 32 | Bank-2 level inputs |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The only state inside the block is the enable mask, so any fault in it shows up at the ports. A bad set or clear decode gives the wrong value on the next read of word 4+b or 8+b. A bad mask also shows one cycle later on `irq_o` and on the summary and pending words while the matching inputs are high. A wrong shortcut index or a wrong bank-flag OR affects only the summary word. The stimulus therefore drives single lines on the shortcut positions and on non-shortcut positions, and checks the exact summary value for each pattern. An off-by-one in the registered output is caught by sampling `irq_o` both before and after the clock edge that follows an input change.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_AW      = 4;
  localparam int REG_DW      = 32;
  localparam int NUM_BANKS   = 3;
  localparam int LOCAL_LINES = 8;
  localparam int PER_LINES   = 32;

  localparam logic [REG_AW-1:0] A_SUMMARY  = 4'd0;
  localparam logic [REG_AW-1:0] A_PEND_BASE = 4'd1;
  localparam logic [REG_AW-1:0] A_SET_BASE  = 4'd4;
  localparam logic [REG_AW-1:0] A_CLR_BASE  = 4'd8;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] wdata;
  } reg_req_t;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank
  import irq_ctrl_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int BANK_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_req_t         req,
  input  logic [LINES-1:0] level_i,
  output logic [LINES-1:0] en_o,
  output logic [LINES-1:0] pend_o
);
  localparam logic [REG_AW-1:0] SET_ADDR = A_SET_BASE + REG_AW'(BANK_ID);
  localparam logic [REG_AW-1:0] CLR_ADDR = A_CLR_BASE + REG_AW'(BANK_ID);

  logic [LINES-1:0] en_q;
  logic             set_hit, clr_hit;

  assign set_hit = req.valid && req.write && (req.addr == SET_ADDR);
  assign clr_hit = req.valid && req.write && (req.addr == CLR_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (set_hit) begin
      en_q <= en_q | req.wdata[LINES-1:0];
    end else if (clr_hit) begin
      en_q <= en_q & ~req.wdata[LINES-1:0];
    end
  end

  assign en_o   = en_q;
  assign pend_o = level_i & en_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_ctrl_pkg::*;
#(
  parameter int          N_SC1   = 5,
  parameter int          N_SC2   = 6,
  parameter logic [24:0] SC1_SEL = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
  parameter logic [29:0] SC2_SEL = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
  input  logic [LOCAL_LINES-1:0] pend0_i,
  input  logic [PER_LINES-1:0]   pend1_i,
  input  logic [PER_LINES-1:0]   pend2_i,
  output logic [REG_DW-1:0]      summary_o
);
  localparam int SC1_LSB = LOCAL_LINES + 2;
  localparam int SC2_LSB = SC1_LSB + N_SC1;
  localparam int USED    = SC2_LSB + N_SC2;

  logic [N_SC1-1:0] sc1;
  logic [N_SC2-1:0] sc2;

  for (genvar i = 0; i < N_SC1; i++) begin : g_sc1
    assign sc1[i] = pend1_i[SC1_SEL[5*i +: 5]];
  end
  for (genvar j = 0; j < N_SC2; j++) begin : g_sc2
    assign sc2[j] = pend2_i[SC2_SEL[5*j +: 5]];
  end

  always_comb begin
    summary_o = '0;
    summary_o[LOCAL_LINES-1:0]     = pend0_i;
    summary_o[LOCAL_LINES]         = |pend1_i;
    summary_o[LOCAL_LINES+1]       = |pend2_i;
    summary_o[SC1_LSB +: N_SC1]    = sc1;
    summary_o[SC2_LSB +: N_SC2]    = sc2;
  end

  if (USED > REG_DW) begin : g_bad_width
    initial $error("summary fields exceed data width");
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [REG_AW-1:0]      bus_addr,
  input  logic [REG_DW-1:0]      bus_wdata,
  output logic [REG_DW-1:0]      bus_rdata,
  input  logic [LOCAL_LINES-1:0] src_local_i,
  input  logic [PER_LINES-1:0]   src_per1_i,
  input  logic [PER_LINES-1:0]   src_per2_i,
  output logic                   irq_o
);
  reg_req_t req;
  assign req = '{valid: bus_valid, write: bus_write, addr: bus_addr, wdata: bus_wdata};

  logic [LOCAL_LINES-1:0] en0, pend0;
  logic [PER_LINES-1:0]   en1, pend1, en2, pend2;
  logic [3*REG_DW-1:0]    en_all;
  logic [REG_DW-1:0]      summary, rd_mux, rdata_q;
  logic                   irq_q;

  irq_en_bank #(.LINES(LOCAL_LINES), .BANK_ID(0)) u_bank0 (
    .clk(clk), .rst(rst), .req(req), .level_i(src_local_i), .en_o(en0), .pend_o(pend0));
  irq_en_bank #(.LINES(PER_LINES), .BANK_ID(1)) u_bank1 (
    .clk(clk), .rst(rst), .req(req), .level_i(src_per1_i), .en_o(en1), .pend_o(pend1));
  irq_en_bank #(.LINES(PER_LINES), .BANK_ID(2)) u_bank2 (
    .clk(clk), .rst(rst), .req(req), .level_i(src_per2_i), .en_o(en2), .pend_o(pend2));

  irq_summary u_summary (
    .pend0_i(pend0), .pend1_i(pend1), .pend2_i(pend2), .summary_o(summary));

  assign en_all = {en2, en1, {(REG_DW-LOCAL_LINES){1'b0}}, en0};

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_SUMMARY:        rd_mux = summary;
      A_PEND_BASE:      rd_mux = REG_DW'(pend0);
      A_PEND_BASE + 1:  rd_mux = pend1;
      A_PEND_BASE + 2:  rd_mux = pend2;
      A_SET_BASE, A_CLR_BASE:         rd_mux = REG_DW'(en0);
      A_SET_BASE + 1, A_CLR_BASE + 1: rd_mux = en1;
      A_SET_BASE + 2, A_CLR_BASE + 2: rd_mux = en2;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_valid && !bus_write) rdata_q <= rd_mux;
      irq_q <= (|pend0) | (|pend1) | (|pend2);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [REG_AW-1:0]      bus_addr,
  input logic [REG_DW-1:0]      bus_wdata,
  input logic [REG_DW-1:0]      bus_rdata,
  input logic [LOCAL_LINES-1:0] src_local_i,
  input logic [PER_LINES-1:0]   src_per1_i,
  input logic [PER_LINES-1:0]   src_per2_i,
  input logic [3*REG_DW-1:0]    en_all,
  input logic                   irq_o
);
  logic any_live;
  assign any_live = |({src_per2_i, src_per1_i, {(REG_DW-LOCAL_LINES){1'b0}}, src_local_i} & en_all);

  logic wr;
  assign wr = bus_valid && bus_write;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (en_all == '0));

  assert_set_bank1_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_SET_BASE + 4'd1) |=>
      (en_all[63:32] == ($past(en_all[63:32]) | $past(bus_wdata))));

  assert_clear_bank2_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_CLR_BASE + 4'd2) |=>
      (en_all[95:64] == ($past(en_all[95:64]) & ~$past(bus_wdata))));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(any_live)));

  assert_no_write_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(en_all));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == 4'd7) |=> (bus_rdata == '0));
endmodule

bind banked_irq_ctrl irq_ctrl_chk u_irq_ctrl_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .src_local_i(src_local_i), .src_per1_i(src_per1_i), .src_per2_i(src_per2_i),
  .en_all(en_all), .irq_o(irq_o));

// File: tb/test_banked_irq_ctrl.sv
`timescale 1ns/1ps
module test_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_local_i = '0;
  logic [31:0] src_per1_i = '0, src_per2_i = '0;
  logic        irq_o;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_local_i(src_local_i), .src_per1_i(src_per1_i), .src_per2_i(src_per2_i),
    .irq_o(irq_o));

  // {local, bank1, bank2, expected summary}
  localparam int NV = 8;
  localparam logic [103:0] VEC [NV] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {8'h81, 32'h0000_0000, 32'h0000_0000, 32'h0000_0081},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0500},
    {8'h00, 32'h0000_0000, 32'h0020_0000, 32'h0000_8200},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0200},
    {8'h01, 32'h000C_0600, 32'h0380_0000, 32'h000E_7B01},
    {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h001F_FF00}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: inputs high but nothing enabled
    src_local_i = '1; src_per1_i = '1; src_per2_i = '1;
    @(negedge clk); @(negedge clk);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    bus_rd(4'd0, rd); check("R1 summary after reset", rd, 32'h0);
    bus_rd(4'd2, rd); check("R1 pending bank1 after reset", rd, 32'h0);
    bus_rd(4'd5, rd); check("R1 enable bank1 after reset", rd, 32'h0);

    // R2 / R4 / R3 on bank 1
    bus_wr(4'd5, 32'h0000_00F0);
    bus_wr(4'd5, 32'h0000_0003);
    bus_rd(4'd5, rd); check("R2 set accumulates", rd, 32'h0000_00F3);
    bus_wr(4'd9, 32'h0000_0011);
    bus_rd(4'd9, rd); check("R3/R4 clear via clear addr", rd, 32'h0000_00E2);
    bus_rd(4'd2, rd); check("R5 masked pending bank1", rd, 32'h0000_00E2);
    bus_rd(4'd0, rd); check("R7/R8 summary partial mask", rd, 32'h0000_0500);

    // R12: writes to read-only / unmapped words
    bus_wr(4'd0, 32'hFFFF_FFFF);
    bus_wr(4'd2, 32'hFFFF_FFFF);
    bus_wr(4'd7, 32'hFFFF_FFFF);
    bus_rd(4'd5, rd); check("R12 enables untouched", rd, 32'h0000_00E2);
    bus_rd(4'd10, rd); check("R12 bank2 enables untouched", rd, 32'h0);
    bus_rd(4'd7, rd); check("R11 unmapped reads zero", rd, 32'h0);
    bus_rd(4'd11, rd); check("R11 unmapped 11 reads zero", rd, 32'h0);
    @(negedge clk);
    check("R11 rdata holds", bus_rdata, 32'h0);

    // R2/R4 bank 0 upper bits ignored
    bus_wr(4'd4, 32'hFFFF_FFFF);
    bus_rd(4'd8, rd); check("R4 bank0 mask width", rd, 32'h0000_00FF);
    bus_rd(4'd1, rd); check("R5 bank0 pending", rd, 32'h0000_00FF);

    // enable everything, walk table
    bus_wr(4'd5, 32'hFFFF_FFFF);
    bus_wr(4'd6, 32'hFFFF_FFFF);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      src_local_i = VEC[k][103:96];
      src_per1_i  = VEC[k][95:64];
      src_per2_i  = VEC[k][63:32];
      @(negedge clk);
      check($sformatf("R9 irq vec%0d", k), {31'b0, irq_o},
            {31'b0, (VEC[k][103:32] != '0)});
      bus_rd(4'd0, rd);
      check($sformatf("R6/R7/R8 summary vec%0d", k), rd, VEC[k][31:0]);
      bus_rd(4'd3, rd);
      check($sformatf("R5 pending bank2 vec%0d", k), rd, VEC[k][63:32]);
    end

    // R9 timing and R10 level drop
    @(negedge clk);
    src_local_i = '0; src_per1_i = '0; src_per2_i = '0;
    @(negedge clk);
    check("R10 irq drops", {31'b0, irq_o}, 32'h0);
    src_per2_i = 32'h0000_0004;
    #1;
    check("R9 irq not yet set before edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq one cycle later", {31'b0, irq_o}, 32'h1);
    src_per2_i = '0;
    bus_rd(4'd3, rd); check("R10 pending clears", rd, 32'h0);
    check("R10 irq clear", {31'b0, irq_o}, 32'h0);

    // R3 on bank 2 then mask stops irq
    bus_wr(4'd10, 32'hFFFF_FFFB);
    src_per2_i = '1;
    @(negedge clk); @(negedge clk);
    bus_rd(4'd3, rd); check("R3 bank2 clear mask", rd, 32'h0000_0004);
    bus_rd(4'd0, rd); check("R7 bank2 flag only", rd, 32'h0000_0200);

    // R1 reset again clears enables
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 irq low after second reset", {31'b0, irq_o}, 32'h0);
    bus_rd(4'd6, rd); check("R1 bank2 enables cleared", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule